// File: doc/BRIEF.md
# Preset-Stop Decimal Timer

This block is a two-digit decimal up-counter that stores each digit as a 4-bit BCD value. After a start pulse it begins at 00 and steps forward once for every clock cycle in which the tick input is high. It stops when the count reaches a target value, which is set on two BCD switch digits. When it stops, it raises an alarm.

The target is compared live on every step, so the switches can be moved while the counter runs. A mode input is captured at start. This mode makes the tens digit wrap after 5, which turns the counter into a 00 to 59 seconds-style counter. Digit decoding for a display and debouncing of the switches are done outside the block.

A typical use is as a kitchen-style preset timer, or as one stage of a clock. Several instances can be driven from a common divided-down tick.

Top module: `bcd_preset_timer`

## Requirements
- R1: A synchronous active-high reset forces the count to 00 and forces running, alarm and error low.
- R2: A start pulse clears the count to 00 on the next edge. If the target is a valid non-zero value, running goes high and alarm goes low. Start overrides a tick in the same cycle, so that tick is not counted. The target is read as bits [7:4] for the tens digit and bits [3:0] for the units digit.
- R3: While running, each cycle with tick high adds one to the count in BCD. The units digit goes from 9 to 0, and the tens digit advances only on that rollover. A cycle with tick low leaves the count unchanged. Each digit always stays in the range 0 to 9.
- R4: If a tick edge makes the count equal to the target, running drops and alarm rises on that same edge. The count then holds at the target, and further ticks are ignored.
- R5: The alarm stays high until the next start or reset.
- R6: The target is compared live on every tick, so a new target set during a run takes effect. The modulo-60 mode input is sampled only at start.
- R7: With the modulo-60 mode captured high, a tick at 59 gives 00 and the counter keeps running. The tens digit never goes above 5.
- R8: With the modulo-60 mode captured low, a tick at 99 gives 00 and the counter keeps running.
- R9: Starting with a target of 00 gives count 00, alarm high and running low right after the start edge. No tick is counted.
- R10: Starting with a target digit in the range 1010 to 1111 sets error high, keeps running and alarm low, and holds the count at 00 no matter what tick does. The next start with a valid target clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clear the count and begin a run |
| tick | input | 1 | Count enable, one step per high cycle |
| mod60_en | input | 1 | Modulo-60 mode request, captured at start |
| target_bcd | input | 8 | Target value: tens digit in [7:4], units digit in [3:0] |
| count_bcd | output | 8 | Current count, in the same digit layout as the target |
| running | output | 1 | High while counting toward the target |
| alarm | output | 1 | High once the target has been reached |
| error | output | 1 | High after a start with an invalid target digit |

## Verification
A start and a tick can arrive in the same cycle. Both of them try to write the count register, through the clear path and the increment path. The bench drives both high on one edge while a run is already under way. It expects 00 with running high afterwards, and then expects a later single tick to give 01. A second collision happens when a live target change meets a rollover. The bench lowers the target below the current count and checks that the count passes 99 to 00 before the match fires.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;
  localparam int unsigned DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE,
    ST_FAULT
  } tmr_state_e;
endpackage

// File: rtl/bcdt_digit.sv
module bcdt_digit #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next,
  output logic         at_limit
);
  // at or above limit counts as the wrap point, so a stray value self-corrects
  always_comb begin
    at_limit = (q >= limit);
    q_next   = q;
    if (clr)
      q_next = '0;
    else if (inc)
      q_next = at_limit ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else
      q <= q_next;
  end
endmodule

// File: rtl/bcdt_compare.sv
module bcdt_compare #(
  parameter int unsigned NDIG = 2,
  parameter int unsigned W    = 4
) (
  input  logic [NDIG*W-1:0] tgt,
  input  logic [NDIG*W-1:0] nxt,
  output logic              hit,
  output logic              tgt_valid,
  output logic              tgt_zero
);
  logic [NDIG-1:0] dig_ok;

  for (genvar i = 0; i < NDIG; i++) begin : g_chk
    assign dig_ok[i] = (tgt[i*W +: W] <= bcdt_pkg::DIG_MAX);
  end

  assign hit       = (nxt == tgt);
  assign tgt_valid = &dig_ok;
  assign tgt_zero  = (tgt == '0);
endmodule

// File: rtl/bcdt_ctrl.sv
module bcdt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic tgt_valid,
  input  logic tgt_zero,
  input  logic hit_next,
  output logic clr,
  output logic adv,
  output logic running,
  output logic alarm,
  output logic error
);
  import bcdt_pkg::*;

  tmr_state_e state_q;

  assign running = (state_q == ST_RUN);
  assign alarm   = (state_q == ST_DONE);
  assign error   = (state_q == ST_FAULT);
  assign clr     = start;
  assign adv     = running && tick && !start;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= ST_IDLE;
    else if (start) begin
      if (!tgt_valid)
        state_q <= ST_FAULT;
      else if (tgt_zero)
        state_q <= ST_DONE;
      else
        state_q <= ST_RUN;
    end else if (adv && hit_next)
      state_q <= ST_DONE;
  end
endmodule

// File: rtl/bcd_preset_timer.sv
module bcd_preset_timer #(
  parameter int unsigned NDIG      = 2,
  parameter int unsigned SHORT_DIG = 1,
  parameter logic [3:0]  SHORT_MAX = 4'd5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         tick,
  input  logic                         mod60_en,
  input  logic [NDIG*bcdt_pkg::DIG_W-1:0] target_bcd,
  output logic [NDIG*bcdt_pkg::DIG_W-1:0] count_bcd,
  output logic                         running,
  output logic                         alarm,
  output logic                         error
);
  localparam int unsigned W  = bcdt_pkg::DIG_W;
  localparam int unsigned VW = NDIG * W;

  logic          mode_q;
  logic          clr, adv, hit, tgt_valid, tgt_zero;
  logic [NDIG-1:0] inc_v, at_lim;
  logic [VW-1:0] nxt_bcd;

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= 1'b0;
    else if (start)
      mode_q <= mod60_en;
  end

  // ripple-free carry: each digit steps when all lower digits sit at their wrap point
  always_comb begin
    inc_v[0] = adv;
    for (int i = 1; i < NDIG; i++)
      inc_v[i] = inc_v[i-1] & at_lim[i-1];
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [W-1:0] lim;
    if (i == SHORT_DIG) begin : g_short
      assign lim = mode_q ? SHORT_MAX : bcdt_pkg::DIG_MAX;
    end else begin : g_full
      assign lim = bcdt_pkg::DIG_MAX;
    end

    bcdt_digit #(.W(W)) u_digit (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .inc      (inc_v[i]),
      .limit    (lim),
      .q        (count_bcd[i*W +: W]),
      .q_next   (nxt_bcd[i*W +: W]),
      .at_limit (at_lim[i])
    );
  end

  bcdt_compare #(.NDIG(NDIG), .W(W)) u_cmp (
    .tgt       (target_bcd),
    .nxt       (nxt_bcd),
    .hit       (hit),
    .tgt_valid (tgt_valid),
    .tgt_zero  (tgt_zero)
  );

  bcdt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tick      (tick),
    .tgt_valid (tgt_valid),
    .tgt_zero  (tgt_zero),
    .hit_next  (hit),
    .clr       (clr),
    .adv       (adv),
    .running   (running),
    .alarm     (alarm),
    .error     (error)
  );
endmodule

// File: rtl/bcd_preset_timer_chk.sv
module bcd_preset_timer_chk #(
  parameter int unsigned NDIG = 2,
  parameter int unsigned W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              tick,
  input logic [NDIG*W-1:0] count_bcd,
  input logic              running,
  input logic              alarm,
  input logic              error,
  input logic              mode_q
);
  logic digits_ok;

  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < NDIG; i++)
      if (count_bcd[i*W +: W] > 4'd9) digits_ok = 1'b0;
  end

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({running, alarm, error})); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (count_bcd == '0)); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(count_bcd)); // R4

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (running && !tick && !start) |=> $stable(count_bcd)); // R3

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm && !start) |=> alarm); // R5

  AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (rst)
    digits_ok); // R3

  AST_MOD60_TENS: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (count_bcd[W +: W] <= 4'd5)); // R7

  AST_ERROR_ZERO: assert property (@(posedge clk) disable iff (rst)
    error |-> (count_bcd == '0)); // R10
endmodule

bind bcd_preset_timer bcd_preset_timer_chk #(.NDIG(NDIG), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .tick      (tick),
  .count_bcd (count_bcd),
  .running   (running),
  .alarm     (alarm),
  .error     (error),
  .mode_q    (mode_q)
);

// File: tb/bcd_preset_timer_test.sv
module bcd_preset_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic       mod60_en = 1'b0;
  logic [7:0] target_bcd = 8'h00;
  logic [7:0] count_bcd;
  logic       running, alarm, error;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_preset_timer uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tick       (tick),
    .mod60_en   (mod60_en),
    .target_bcd (target_bcd),
    .count_bcd  (count_bcd),
    .running    (running),
    .alarm      (alarm),
    .error      (error)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_status(input string req, input logic [7:0] cnt,
                              input logic r, input logic a, input logic e);
    check(req, count_bcd, cnt);
    check(req, {5'd0, running, alarm, error}, {5'd0, r, a, e});
  endtask

  task automatic do_start(input logic [7:0] tgt, input logic m60);
    target_bcd = tgt;
    mod60_en   = m60;
    start      = 1'b1;
    step();
    start      = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    check_status("R1 reset", 8'h00, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_basic();
    do_start(8'h12, 1'b0);
    check_status("R2 start", 8'h00, 1'b1, 1'b0, 1'b0);
    ticks(10);
    check_status("R3 tens carry", 8'h10, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R3 step", 8'h11, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R4 match", 8'h12, 1'b0, 1'b1, 1'b0);
    ticks(3);
    check_status("R4 hold at target", 8'h12, 1'b0, 1'b1, 1'b0);
    repeat (5) step();
    check_status("R5 alarm sticky", 8'h12, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_gaps_and_collision();
    do_start(8'h40, 1'b0);
    for (int i = 0; i < 3; i++) begin
      ticks(1);
      step();
      step();
    end
    check_status("R3 tick gaps hold", 8'h03, 1'b1, 1'b0, 1'b0);
    start = 1'b1;
    tick  = 1'b1;
    step();
    start = 1'b0;
    tick  = 1'b0;
    check_status("R2 start beats tick", 8'h00, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R2 after collision", 8'h01, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_live_target_wrap99();
    do_start(8'h05, 1'b0);
    ticks(2);
    target_bcd = 8'h01;
    ticks(97);
    check_status("R6 lowered target passed", 8'h99, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R8 wrap 99", 8'h00, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R6 live target match", 8'h01, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_mod60();
    do_start(8'h99, 1'b1);
    mod60_en = 1'b0;
    ticks(59);
    check_status("R7 reach 59", 8'h59, 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_status("R7 wrap 59", 8'h00, 1'b1, 1'b0, 1'b0);
    ticks(61);
    check_status("R6 mode captured", 8'h01, 1'b1, 1'b0, 1'b0);
    do_start(8'h45, 1'b1);
    ticks(45);
    check_status("R7 match in mode", 8'h45, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_zero();
    do_start(8'h00, 1'b0);
    check_status("R9 zero target", 8'h00, 1'b0, 1'b1, 1'b0);
    ticks(2);
    check_status("R9 no ticks counted", 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_invalid();
    do_start(8'h1A, 1'b0);
    check_status("R10 bad units", 8'h00, 1'b0, 1'b0, 1'b1);
    ticks(3);
    check_status("R10 ticks ignored", 8'h00, 1'b0, 1'b0, 1'b1);
    do_start(8'hB3, 1'b0);
    check_status("R10 bad tens", 8'h00, 1'b0, 1'b0, 1'b1);
    do_start(8'h02, 1'b0);
    check_status("R10 cleared", 8'h00, 1'b1, 1'b0, 1'b0);
    ticks(2);
    check_status("R10 runs after clear", 8'h02, 1'b0, 1'b1, 1'b0);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check_status("R1 reset clears alarm", 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_basic();
    t_gaps_and_collision();
    t_live_target_wrap99();
    t_mod60();
    t_zero();
    t_invalid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung, expected finished");
      summary();
      $finish;
    end
  end
endmodule